// File: doc/BRIEF.md
# Extended palette DAC port

This block sits behind the palette data port of a display controller. It owns the colour-component sequencer that the port uses. That sequencer has a read index, a write index, a mode flag and a three-step component counter. Depending on an enable bit taken from the cursor attribute register, each data access goes one of two ways. With the bit clear, the access is steered to an external 256-entry colour table. With the bit set, it is steered to a small internal extended palette. That palette holds the hardware cursor colours and the border colour.

Software first writes an index through one of two index-set strobes, which also selects read or write mode. It then moves colours through the data port as red, green, blue triplets. The active index advances after every complete triplet. The external table receives the active index, the component number and one-cycle strobes. The internal palette uses only the low bits of the index. Three fixed entries of the internal palette are always presented as packed 24-bit colours for the cursor and border drawing logic.

Top module: `xpal_port`

## Requirements
- R1: After reset the mode is write, both indices and the component counter are 0, every extended palette entry is zero (so all three colour outputs read 0), and `rdata` is 0x00.
- R2: With `xpal_en` low, a data access that is honoured pulses `std_we` (write) or `std_re` (read) for that cycle. The external table is addressed by `dac_idx` and `dac_comp`. Read data is taken from `std_rdata`. The extended palette is not changed.
- R3: With `xpal_en` high, an honoured access reaches extended entry `dac_idx` modulo 16 (the low 4 index bits). `std_we` and `std_re` stay low.
- R4: The component counter on `dac_comp` steps 0 (red), 1 (green), 2 (blue) on successive honoured accesses. It never shows 3.
- R5: An honoured access at component 2 returns the counter to 0 and increments the active index by one. The index wraps from 255 to 0.
- R6: An `idx_wr_set` or `idx_rd_set` strobe loads `wdata` into that mode's index, selects that mode and clears the counter, even in the middle of a triplet. If both strobes are high, the write strobe wins. In a cycle with an index-set strobe, data strobes are ignored.
- R7: A data read in write mode returns 0xFF on `rdata` and leaves the counter and index unchanged.
- R8: A data write in read mode is ignored: there is no storage change, no `std_we`, and no counter or index change. If a read strobe comes in the same cycle, the read is served.
- R9: `dac_idx` shows the read index in read mode and the write index in write mode.
- R10: `col_bg`, `col_border` and `col_fg` show extended entries 0, 2 and 15, packed as red in bits 23:16, green in 15:8 and blue in 7:0.
- R11: `rdata` is registered. It changes in the cycle after an honoured read or a wrong-mode read, and holds its value until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xpal_en | input | 1 | Steers data accesses to the extended palette when high |
| idx_rd_set | input | 1 | Load read index from `wdata`, enter read mode |
| idx_wr_set | input | 1 | Load write index from `wdata`, enter write mode |
| data_rd | input | 1 | Data port read strobe |
| data_wr | input | 1 | Data port write strobe |
| wdata | input | 8 | Index or colour component byte |
| rdata | output | 8 | Registered read data |
| std_we | output | 1 | Write strobe to external colour table |
| std_re | output | 1 | Read strobe to external colour table |
| dac_idx | output | 8 | Active index |
| dac_comp | output | 2 | Active component (0 red, 1 green, 2 blue) |
| std_rdata | input | 8 | Component read from external table at `dac_idx`/`dac_comp` |
| col_bg | output | 24 | Extended entry 0, cursor background |
| col_border | output | 24 | Extended entry 2, border colour |
| col_fg | output | 24 | Extended entry 15, cursor foreground |

## Verification
The bench builds the block with its defaults: 8-bit data and index, and 16 extended entries. With these values the 255-to-0 index wrap can be reached in a single triplet. The aliasing of high index values onto the 16 extended entries, and the end taps at entries 0 and 15, are also reachable. A behavioural model holding the full 16-entry palette and a 256-entry external table predicts every registered and strobe output each cycle. This covers mode switches in the middle of a triplet, simultaneous strobes and wrong-mode accesses.

// File: rtl/xpal_pkg.sv
package xpal_pkg;
  typedef enum logic {MODE_RD = 1'b0, MODE_WR = 1'b1} xpal_mode_e;
  typedef logic [1:0] comp_sel_t;
  localparam int unsigned N_COMP   = 3;
  localparam comp_sel_t   COMP_RED = 2'd0;
  localparam comp_sel_t   COMP_BLU = 2'd2;
endpackage

// File: rtl/xpal_seq.sv
module xpal_seq
  import xpal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_rd_set,
  input  logic             idx_wr_set,
  input  logic             data_rd,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] idx_val,
  output xpal_mode_e       mode,
  output logic [IDX_W-1:0] act_idx,
  output comp_sel_t        step,
  output logic             rd_fire,
  output logic             wr_fire,
  output logic             rd_bad
);
  xpal_mode_e       mode_q, mode_n;
  logic [IDX_W-1:0] rd_idx_q, rd_idx_n, wr_idx_q, wr_idx_n;
  comp_sel_t        step_q, step_n;
  logic             any_set, upd;

  // next-state
  always_comb begin
    any_set  = idx_rd_set | idx_wr_set;
    wr_fire  = data_wr & ~any_set & (mode_q == MODE_WR);
    rd_fire  = data_rd & ~any_set & (mode_q == MODE_RD);
    rd_bad   = data_rd & ~any_set & (mode_q == MODE_WR);
    upd      = any_set | wr_fire | rd_fire;
    mode_n   = mode_q;
    rd_idx_n = rd_idx_q;
    wr_idx_n = wr_idx_q;
    step_n   = step_q;
    if (idx_wr_set) begin
      wr_idx_n = idx_val;
      mode_n   = MODE_WR;
      step_n   = COMP_RED;
    end else if (idx_rd_set) begin
      rd_idx_n = idx_val;
      mode_n   = MODE_RD;
      step_n   = COMP_RED;
    end else if (wr_fire | rd_fire) begin
      if (step_q == COMP_BLU) begin
        step_n = COMP_RED;
        if (mode_q == MODE_WR) wr_idx_n = wr_idx_q + 1'b1;
        else                   rd_idx_n = rd_idx_q + 1'b1;
      end else begin
        step_n = step_q + 2'd1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_WR;
      rd_idx_q <= '0;
      wr_idx_q <= '0;
      step_q   <= COMP_RED;
    end else if (upd) begin
      mode_q   <= mode_n;
      rd_idx_q <= rd_idx_n;
      wr_idx_q <= wr_idx_n;
      step_q   <= step_n;
    end
  end

  assign mode    = mode_q;
  assign act_idx = (mode_q == MODE_RD) ? rd_idx_q : wr_idx_q;
  assign step    = step_q;
endmodule

// File: rtl/xpal_store.sv
module xpal_store
  import xpal_pkg::*;
#(
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned COMP_W   = 8,
  parameter int unsigned TAP_BG   = 0,
  parameter int unsigned TAP_BRD  = 2,
  parameter int unsigned TAP_FG   = 15,
  localparam int unsigned SEL_W   = $clog2(ENTRIES),
  localparam int unsigned FLAT_W  = ENTRIES * N_COMP * COMP_W,
  localparam int unsigned COL_W   = N_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  comp_sel_t         comp,
  input  logic [COMP_W-1:0] wdata,
  output logic [COMP_W-1:0] rd_val,
  output logic [COL_W-1:0]  tap_bg,
  output logic [COL_W-1:0]  tap_brd,
  output logic [COL_W-1:0]  tap_fg
);
  logic [FLAT_W-1:0] flat;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
      logic [COMP_W-1:0] cell_q;
      logic              cell_en;
      assign cell_en = we && (sel == SEL_W'(e)) && (comp == 2'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cell_q <= '0;
        else if (cell_en) cell_q <= wdata;
      end
      assign flat[(e*N_COMP + c)*COMP_W +: COMP_W] = cell_q;
    end
    // entry packed red-high: component 0 lands in the top byte
    if (e == TAP_BG) begin : g_bg
      assign tap_bg = {flat[(e*N_COMP)*COMP_W +: COMP_W],
                       flat[(e*N_COMP+1)*COMP_W +: COMP_W],
                       flat[(e*N_COMP+2)*COMP_W +: COMP_W]};
    end
    if (e == TAP_BRD) begin : g_brd
      assign tap_brd = {flat[(e*N_COMP)*COMP_W +: COMP_W],
                        flat[(e*N_COMP+1)*COMP_W +: COMP_W],
                        flat[(e*N_COMP+2)*COMP_W +: COMP_W]};
    end
    if (e == TAP_FG) begin : g_fg
      assign tap_fg = {flat[(e*N_COMP)*COMP_W +: COMP_W],
                       flat[(e*N_COMP+1)*COMP_W +: COMP_W],
                       flat[(e*N_COMP+2)*COMP_W +: COMP_W]};
    end
  end

  always_comb begin
    rd_val = flat[(int'(sel)*N_COMP + int'(comp))*COMP_W +: COMP_W];
  end
endmodule

// File: rtl/xpal_rmux.sv
module xpal_rmux #(
  parameter int unsigned COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              rd_bad,
  input  logic              use_ext,
  input  logic [COMP_W-1:0] ext_val,
  input  logic [COMP_W-1:0] std_val,
  output logic [COMP_W-1:0] rdata
);
  logic [COMP_W-1:0] rdata_q, rdata_n;
  logic              cap_en;

  always_comb begin
    cap_en  = rd_fire | rd_bad;
    rdata_n = rd_bad ? '1 : (use_ext ? ext_val : std_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= rdata_n;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/xpal_port.sv
module xpal_port
  import xpal_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned BG_ENTRY   = 0,
  parameter int unsigned BRD_ENTRY  = 2,
  parameter int unsigned FG_ENTRY   = ENTRIES - 1,
  localparam int unsigned SEL_W     = $clog2(ENTRIES),
  localparam int unsigned COL_W     = N_COMP * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xpal_en,
  input  logic              idx_rd_set,
  input  logic              idx_wr_set,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              std_we,
  output logic              std_re,
  output logic [DATA_W-1:0] dac_idx,
  output logic [1:0]        dac_comp,
  input  logic [DATA_W-1:0] std_rdata,
  output logic [COL_W-1:0]  col_bg,
  output logic [COL_W-1:0]  col_border,
  output logic [COL_W-1:0]  col_fg
);
  xpal_mode_e        cur_mode;
  logic [DATA_W-1:0] act_idx;
  comp_sel_t         step;
  logic              rd_fire, wr_fire, rd_bad, x_we;
  logic [DATA_W-1:0] x_rd_val;

  xpal_seq #(.IDX_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_rd_set (idx_rd_set),
    .idx_wr_set (idx_wr_set),
    .data_rd    (data_rd),
    .data_wr    (data_wr),
    .idx_val    (wdata),
    .mode       (cur_mode),
    .act_idx    (act_idx),
    .step       (step),
    .rd_fire    (rd_fire),
    .wr_fire    (wr_fire),
    .rd_bad     (rd_bad)
  );

  assign x_we     = wr_fire & xpal_en;
  assign std_we   = wr_fire & ~xpal_en;
  assign std_re   = rd_fire & ~xpal_en;
  assign dac_idx  = act_idx;
  assign dac_comp = step;

  xpal_store #(
    .ENTRIES (ENTRIES),
    .COMP_W  (DATA_W),
    .TAP_BG  (BG_ENTRY),
    .TAP_BRD (BRD_ENTRY),
    .TAP_FG  (FG_ENTRY)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (x_we),
    .sel     (act_idx[SEL_W-1:0]),
    .comp    (step),
    .wdata   (wdata),
    .rd_val  (x_rd_val),
    .tap_bg  (col_bg),
    .tap_brd (col_border),
    .tap_fg  (col_fg)
  );

  xpal_rmux #(.COMP_W(DATA_W)) u_rmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .rd_bad  (rd_bad),
    .use_ext (xpal_en),
    .ext_val (x_rd_val),
    .std_val (std_rdata),
    .rdata   (rdata)
  );
endmodule

// File: rtl/xpal_port_chk.sv
module xpal_port_chk
  import xpal_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COL_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xpal_en,
  input logic              idx_rd_set,
  input logic              idx_wr_set,
  input logic              data_rd,
  input logic              data_wr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              std_we,
  input logic              std_re,
  input logic [DATA_W-1:0] dac_idx,
  input logic [1:0]        dac_comp,
  input logic [COL_W-1:0]  col_fg,
  input logic [COL_W-1:0]  col_border,
  input logic [COL_W-1:0]  col_bg,
  input xpal_mode_e        cur_mode
);
  logic quiet;
  assign quiet = !idx_rd_set && !idx_wr_set;

  // R4
  comp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_comp != 2'd3);

  // R2
  std_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (std_we || std_re) |-> !xpal_en);

  // R6
  wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_set |=> (cur_mode == MODE_WR) && (dac_comp == 2'd0) && (dac_idx == $past(wdata)));

  // R6
  rd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rd_set && !idx_wr_set) |=> (cur_mode == MODE_RD) && (dac_comp == 2'd0) && (dac_idx == $past(wdata)));

  // R7
  bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && quiet && cur_mode == MODE_WR) |=> (rdata == '1) && $stable(dac_comp));

  // R8
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !data_rd && quiet && cur_mode == MODE_RD)
      |=> $stable(col_fg) && $stable(col_bg) && $stable(col_border) && $stable(dac_comp) && $stable(dac_idx));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && quiet && cur_mode == MODE_WR && dac_comp == 2'd2)
      |=> (dac_comp == 2'd0) && (dac_idx == DATA_W'($past(dac_idx) + 1'b1)));

  // R3
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xpal_en |-> !std_we && !std_re);
endmodule

bind xpal_port xpal_port_chk #(.DATA_W(DATA_W), .COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xpal_en    (xpal_en),
  .idx_rd_set (idx_rd_set),
  .idx_wr_set (idx_wr_set),
  .data_rd    (data_rd),
  .data_wr    (data_wr),
  .wdata      (wdata),
  .rdata      (rdata),
  .std_we     (std_we),
  .std_re     (std_re),
  .dac_idx    (dac_idx),
  .dac_comp   (dac_comp),
  .col_fg     (col_fg),
  .col_border (col_border),
  .col_bg     (col_bg),
  .cur_mode   (cur_mode)
);

// File: tb/xpal_port_bench.sv
module xpal_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xpal_en, idx_rd_set, idx_wr_set, data_rd, data_wr;
  logic [7:0]  wdata, rdata, dac_idx, std_rdata;
  logic        std_we, std_re;
  logic [1:0]  dac_comp;
  logic [23:0] col_bg, col_border, col_fg;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc_cnt = 0;
  string cur_req = "R1";

  // external colour table
  logic [7:0] std_mem [0:255][0:2];
  assign std_rdata = std_mem[dac_idx][dac_comp];
  always @(posedge clk) if (std_we) std_mem[dac_idx][dac_comp] <= wdata;

  // reference model
  bit         m_wr;
  int         ridx, widx, stp;
  logic [7:0] xp [0:15][0:2];
  logic [7:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpal_port u_xpal_port (
    .clk(clk), .rst_n(rst_n), .xpal_en(xpal_en), .idx_rd_set(idx_rd_set),
    .idx_wr_set(idx_wr_set), .data_rd(data_rd), .data_wr(data_wr), .wdata(wdata),
    .rdata(rdata), .std_we(std_we), .std_re(std_re), .dac_idx(dac_idx),
    .dac_comp(dac_comp), .std_rdata(std_rdata), .col_bg(col_bg),
    .col_border(col_border), .col_fg(col_fg)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WDOG_LIMIT) begin
      n_tests++; n_fail++;
      $display("FAIL %s watchdog act=%0d exp=<%0d", cur_req, cyc_cnt, WDOG_LIMIT);
      summary();
      $finish;
    end
  end

  // one clock: check registered outputs, drive, check strobes, advance model
  task automatic cyc(logic iws, logic irs, logic dwr, logic drd, logic [7:0] d, logic en);
    logic sets, adv;
    chk("rdata", rdata, m_rdata);
    chk("col_bg R10", col_bg, {xp[0][0], xp[0][1], xp[0][2]});
    chk("col_border R10", col_border, {xp[2][0], xp[2][1], xp[2][2]});
    chk("col_fg R10", col_fg, {xp[15][0], xp[15][1], xp[15][2]});
    idx_wr_set = iws; idx_rd_set = irs; data_wr = dwr; data_rd = drd; wdata = d; xpal_en = en;
    #1;
    sets = iws | irs;
    chk("dac_idx R9", dac_idx, m_wr ? widx : ridx);
    chk("dac_comp R4", dac_comp, stp);
    chk("std_we", std_we, dwr && !sets && m_wr && !en);
    chk("std_re", std_re, drd && !sets && !m_wr && !en);
    if (iws) begin
      widx = d; m_wr = 1; stp = 0;
    end else if (irs) begin
      ridx = d; m_wr = 0; stp = 0;
    end else begin
      adv = 0;
      if (dwr && m_wr) begin
        if (en) xp[widx % 16][stp] = d;
        adv = 1;
      end
      if (drd) begin
        if (!m_wr) begin
          m_rdata = en ? xp[ridx % 16][stp] : std_mem[ridx][stp];
          adv = 1;
        end else m_rdata = 8'hFF;
      end
      if (adv) begin
        if (stp == 2) begin
          stp = 0;
          if (m_wr) widx = (widx + 1) % 256; else ridx = (ridx + 1) % 256;
        end else stp++;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n, logic en);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00, en);
  endtask
  task automatic wset(logic [7:0] d, logic en); cyc(1, 0, 0, 0, d, en); endtask
  task automatic rset(logic [7:0] d, logic en); cyc(0, 1, 0, 0, d, en); endtask
  task automatic wr(logic [7:0] d, logic en);   cyc(0, 0, 1, 0, d, en); endtask
  task automatic rd(logic en);                  cyc(0, 0, 0, 1, 8'h00, en); endtask

  initial begin
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) std_mem[i][c] = 8'((i * 3 + c) ^ 8'h5A);
    for (int e = 0; e < 16; e++)
      for (int c = 0; c < 3; c++) xp[e][c] = 8'h00;
    m_wr = 1; ridx = 0; widx = 0; stp = 0; m_rdata = 8'h00;
    rst_n = 0; xpal_en = 0; idx_rd_set = 0; idx_wr_set = 0;
    data_rd = 0; data_wr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R1"; idle(2, 0);

    cur_req = "R3";                       // entries 0,1 via alias 0x20, entry 15 via 0x0F
    wset(8'h20, 1);
    for (int k = 0; k < 6; k++) wr(8'(8'h11 + k * 8'h11), 1);
    wset(8'h0F, 1); wr(8'hF1, 1); wr(8'hF2, 1); wr(8'hF3, 1);

    cur_req = "R10"; wset(8'hF2, 1); wr(8'hA0, 1); wr(8'hB0, 1); wr(8'hC0, 1); idle(1, 1);

    cur_req = "R4"; rset(8'h00, 1);
    for (int k = 0; k < 6; k++) rd(1);

    cur_req = "R11"; idle(3, 1); rd(1); idle(2, 0);

    cur_req = "R5"; wset(8'hFF, 1); wr(8'h01, 1); wr(8'h02, 1); wr(8'h03, 1);
    wr(8'h04, 1); wr(8'h05, 1); wr(8'h06, 1);
    rset(8'hFF, 1); for (int k = 0; k < 5; k++) rd(1);

    cur_req = "R6"; wset(8'h02, 1); wr(8'h77, 1);
    cyc(1, 1, 0, 0, 8'h03, 1);            // both set: write wins
    wr(8'h31, 1); rset(8'h10, 1); rd(1);
    cyc(0, 1, 0, 1, 8'h0F, 1);            // set beats same-cycle read
    rd(1); rd(1);

    cur_req = "R7"; wset(8'h05, 1); wr(8'h55, 1); rd(1); rd(1); wr(8'h56, 1);

    cur_req = "R8"; rset(8'h00, 1); wr(8'hEE, 1); rd(1);
    cyc(0, 0, 1, 1, 8'hDD, 1); rd(1); idle(1, 1);

    cur_req = "R9"; wset(8'h33, 0); rset(8'h44, 0); rd(0); wset(8'h09, 0); idle(1, 0);

    cur_req = "R2"; wset(8'h40, 0); wr(8'h9A, 0); wr(8'h9B, 0); wr(8'h9C, 0);
    rset(8'h40, 0); rd(0); rd(0); rd(0); rd(0);
    rset(8'h02, 1); rd(1); rd(1); rd(1); idle(2, 1);

    summary();
    $finish;
  end
endmodule